// File: doc/BRIEF.md
# Line Output Latch with Polarity Steering

This block sits between the shift-loaded data register of a column driver and its per-channel converters. Once per horizontal line a strobe pulse arrives. On the strobe's rising edge the block takes a snapshot of every channel's 8-bit gray code and of the polarity input. On the strobe's falling edge it commits that snapshot to the channel outputs and enables drive. Each channel output carries its code and a one-bit reference-group select. Adjacent channels always select opposite groups, and the polarity input decides which group the odd-numbered channels take.

The strobe is treated as synchronous to the system clock, and both of its edges are detected by comparing it with its value at the previous clock. A strobe that goes high again after only one low clock overlaps a commit that is still in progress, and the block reports this on a one-cycle error flag. An active-low power-saving input is passed to a registered bias-reduction flag.

Top module: `line_drive_latch`

## Requirements
- R1: While reset is held and after it is released, until the first commit, every code output is 0, every group select is 0, and `drive_en`, `bias_low` and `strobe_err` are 0.
- R2: Channel data is sampled at the first clock edge that sees `strobe` high after a low. Changes to `line_data` after that edge do not alter the line that is committed.
- R3: Outputs change only at the clock edge one cycle after the first edge that sees `strobe` low following a high. At all other times the previous line is held, including while the strobe is high.
- R4: With the captured polarity 0, channels with index 0, 2, 4, … (odd-numbered outputs 1, 3, 5, …) select group 0 (lower levels) and channels with index 1, 3, … select group 1.
- R5: With the captured polarity 1, the selection in R4 is swapped: even indices select group 1 and odd indices select group 0.
- R6: Polarity is sampled at the same edge as the data (R2). A polarity change while the strobe is high has no effect on that line.
- R7: `drive_en` goes to 1 at the first commit and stays at 1 until reset.
- R8: `bias_low` equals the inverse of `low_power_n`, delayed by one clock, whatever the strobe does.
- R9: `strobe_err` pulses for one cycle, at the edge after the rise is seen, when a rising strobe edge is detected while a commit is still pending (the strobe was low for exactly one clock). If the strobe was low for two or more clocks, it stays 0. The line is still captured and committed normally.
- R10: Channel i's code output is bits [8i+7:8i] of `line_data`, passed through without any change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_data | input | NUM_CH*CODE_W | Data register contents, channel i at bits [CODE_W*i +: CODE_W] |
| strobe | input | 1 | Line strobe: rise captures, fall commits |
| polarity | input | 1 | Group steering for the captured line |
| low_power_n | input | 1 | Active-low power-saving request |
| out_code | output | NUM_CH*CODE_W | Committed per-channel gray codes |
| out_grp | output | NUM_CH | Per-channel reference group select (0 lower, 1 upper) |
| drive_en | output | 1 | Outputs enabled after first commit |
| bias_low | output | 1 | Registered bias-reduction flag |
| strobe_err | output | 1 | One-cycle pulse on overlapping strobe |

## Verification
The hardest case to reach from the ports is the overlap error. It needs the strobe to drop for exactly one clock, so that the new rise lands on the edge where the previous commit is still pending. The scoreboard driver therefore takes the strobe high and low times in clocks as arguments. It runs back-to-back lines with a one-clock low gap, and compares them with lines that have two-clock and longer gaps. While the strobe is high, the driver also scrambles the data and polarity to show that only the rising-edge values reach the outputs.

// File: rtl/line_latch_pkg.sv
// Package: shared constants and types for the line output latch.
// Assumes nothing beyond IEEE 1800-2017 packages.
package line_latch_pkg;

    // Reference group select encoding seen by the downstream converter
    typedef enum logic {
        GRP_LOWER = 1'b0,
        GRP_UPPER = 1'b1
    } ref_grp_e;

    // Default code width of one channel
    localparam int unsigned DEF_CODE_W = 8;

    // Group for a channel given its index parity and the captured polarity.
    // Index 0 is output number 1 (odd-numbered).
    function automatic ref_grp_e steer_grp(input logic idx_even, input logic pol);
        ref_grp_e g;
        if (idx_even) g = pol ? GRP_UPPER : GRP_LOWER;
        else          g = pol ? GRP_LOWER : GRP_UPPER;
        return g;
    endfunction

endpackage

// File: rtl/lda_strobe_ctl.sv
// Module: lda_strobe_ctl
// Detects strobe edges against the previous clock's strobe value, produces a
// capture pulse on the rising edge and a commit request one cycle after the
// falling edge, and flags a rise that lands while a commit is still pending.
// Assumes: strobe is synchronous to clk (no metastability handling here).
module lda_strobe_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic cap_pulse,
    output logic commit_req,
    output logic strobe_err
);

    logic strobe_q;
    logic rise_det;
    logic fall_det;

    // Edge detection against the sampled previous strobe level
    assign rise_det  = strobe & ~strobe_q;
    assign fall_det  = ~strobe & strobe_q;
    assign cap_pulse = rise_det;

    // Remember the strobe level from the last clock
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe;
    end

    // Commit request: set by a detected fall, consumed the next cycle
    always_ff @(posedge clk) begin
        if (!rst_n) commit_req <= 1'b0;
        else        commit_req <= fall_det;
    end

    // Overlap error: rise seen while a commit is still outstanding
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_err <= 1'b0;
        else        strobe_err <= rise_det & commit_req;
    end

    // A commit can never be requested two cycles in a row (R3)
    p_single_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        commit_req |=> !commit_req);

    // Error pulse lasts one cycle only (R9)
    p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_err |=> !strobe_err);

endmodule

// File: rtl/lda_line_store.sv
// Module: lda_line_store
// Holds the snapshot of all channel codes and the polarity taken at the
// strobe's rising edge. Assumes cap_pulse is a one-cycle pulse.
module lda_line_store #(
    parameter int unsigned NUM_CH = 384,
    parameter int unsigned CODE_W = 8,
    localparam int unsigned BUS_W = NUM_CH * CODE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_pulse,
    input  logic [BUS_W-1:0] line_data,
    input  logic             polarity,
    output logic [BUS_W-1:0] held_data,
    output logic             held_pol
);

    // Snapshot data and polarity together on a capture pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_data <= '0;
            held_pol  <= 1'b0;
        end else if (cap_pulse) begin
            held_data <= line_data;
            held_pol  <= polarity;
        end
    end

    // Snapshot only moves on a capture (R2, R6)
    p_hold_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_pulse |=> $stable(held_data));

    p_hold_pol_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_pulse |=> $stable(held_pol));

endmodule

// File: rtl/lda_out_stage.sv
// Module: lda_out_stage
// Per-channel output registers: on a commit each channel takes its code from
// the snapshot and a group select steered by snapshot polarity and channel
// index parity. Also owns drive enable and the bias-reduction flag.
// Assumes commit_req is a one-cycle pulse; NUM_CH >= 2.
module lda_out_stage
    import line_latch_pkg::*;
#(
    parameter int unsigned NUM_CH = 384,
    parameter int unsigned CODE_W = 8,
    localparam int unsigned BUS_W = NUM_CH * CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_req,
    input  logic [BUS_W-1:0]  held_data,
    input  logic              held_pol,
    input  logic              low_power_n,
    output logic [BUS_W-1:0]  out_code,
    output logic [NUM_CH-1:0] out_grp,
    output logic              drive_en,
    output logic              bias_low
);

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CH; gi++) begin : g_ch
            localparam logic IDX_EVEN = ((gi % 2) == 0);
            ref_grp_e grp_nxt;

            // Group steering for this channel
            always_comb grp_nxt = steer_grp(IDX_EVEN, held_pol);

            // Channel register: load code and group on commit
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    out_code[gi*CODE_W +: CODE_W] <= '0;
                    out_grp[gi]                   <= 1'b0;
                end else if (commit_req) begin
                    out_code[gi*CODE_W +: CODE_W] <= held_data[gi*CODE_W +: CODE_W];
                    out_grp[gi]                   <= grp_nxt;
                end
            end
        end
    endgenerate

    // Drive enable: sticky after the first commit
    always_ff @(posedge clk) begin
        if (!rst_n)          drive_en <= 1'b0;
        else if (commit_req) drive_en <= 1'b1;
    end

    // Bias flag: registered inverse of the power-saving request
    always_ff @(posedge clk) begin
        if (!rst_n) bias_low <= 1'b0;
        else        bias_low <= ~low_power_n;
    end

    // Outputs hold between commits (R3)
    p_hold_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_req |=> ($stable(out_code) && $stable(out_grp)));

    // Drive enable never drops outside reset (R7)
    p_drive_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |=> drive_en);

    // Neighbouring channels use opposite groups once driving (R4)
    p_pair_opposite_r4: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> (out_grp[0] != out_grp[1]));

endmodule

// File: rtl/line_drive_latch.sv
// Module: line_drive_latch (top)
// Once-per-line output latch for a column driver: strobe rise snapshots all
// channel codes and polarity, strobe fall commits them to the outputs with
// per-channel group steering. Assumes strobe synchronous to clk.
module line_drive_latch
    import line_latch_pkg::*;
#(
    parameter int unsigned NUM_CH = 384,
    parameter int unsigned CODE_W = DEF_CODE_W,
    localparam int unsigned BUS_W = NUM_CH * CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_W-1:0]  line_data,
    input  logic              strobe,
    input  logic              polarity,
    input  logic              low_power_n,
    output logic [BUS_W-1:0]  out_code,
    output logic [NUM_CH-1:0] out_grp,
    output logic              drive_en,
    output logic              bias_low,
    output logic              strobe_err
);

    logic             cap_pulse;
    logic             commit_req;
    logic [BUS_W-1:0] held_data;
    logic             held_pol;

    lda_strobe_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe     (strobe),
        .cap_pulse  (cap_pulse),
        .commit_req (commit_req),
        .strobe_err (strobe_err)
    );

    lda_line_store #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_pulse (cap_pulse),
        .line_data (line_data),
        .polarity  (polarity),
        .held_data (held_data),
        .held_pol  (held_pol)
    );

    lda_out_stage #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit_req  (commit_req),
        .held_data   (held_data),
        .held_pol    (held_pol),
        .low_power_n (low_power_n),
        .out_code    (out_code),
        .out_grp     (out_grp),
        .drive_en    (drive_en),
        .bias_low    (bias_low)
    );

    // Before any drive, outputs sit at zero (R1)
    p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_en |-> (out_code == '0 && out_grp == '0));

endmodule

// File: tb/line_drive_latch_tb.sv
module line_drive_latch_tb;

    localparam int NCH = 384;
    localparam int CW  = 8;
    localparam int BW  = NCH * CW;

    typedef struct {
        int            due;
        logic [BW-1:0] data;
        logic          pol;
    } item_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [BW-1:0]   line_data = '0;
    logic            strobe = 1'b0;
    logic            polarity = 1'b0;
    logic            low_power_n = 1'b1;
    logic [BW-1:0]   out_code;
    logic [NCH-1:0]  out_grp;
    logic            drive_en;
    logic            bias_low;
    logic            strobe_err;

    int    cyc = 0;
    int    n_checks = 0;
    int    n_errors = 0;
    bit    mon_on = 1'b0;
    bit    done = 1'b0;
    int    err_due = -1;
    int    last_low = 100;
    item_t q[$];

    logic [BW-1:0]  exp_code = '0;
    logic           exp_pol = 1'b0;
    logic           exp_drv = 1'b0;
    logic [NCH-1:0] exp_grp;
    logic           bias_model = 1'b0;

    always #5 clk = ~clk;

    line_drive_latch u_dut (
        .clk(clk), .rst_n(rst_n), .line_data(line_data), .strobe(strobe),
        .polarity(polarity), .low_power_n(low_power_n), .out_code(out_code),
        .out_grp(out_grp), .drive_en(drive_en), .bias_low(bias_low),
        .strobe_err(strobe_err)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) bias_model <= 1'b0;
        else        bias_model <= ~low_power_n;
    end

    function automatic logic [BW-1:0] make_line(input int seed);
        logic [BW-1:0] v;
        for (int i = 0; i < NCH; i++)
            v[i*CW +: CW] = 8'((i * seed) + (seed >> 2) + (i >> 3));
        return v;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [BW-1:0] act,
                         input logic [BW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
        end
    endtask

    // Driver: one line, strobe high for hi clocks, low for lo clocks after
    task automatic send_line(input logic [BW-1:0] d, input logic p,
                             input int hi, input int lo, input bit scramble);
        item_t it;
        line_data = d;
        polarity  = p;
        strobe    = 1'b1;
        it.due  = cyc + hi + 2;
        it.data = d;
        it.pol  = p;
        q.push_back(it);
        if (last_low == 1) err_due = cyc + 1;   // R9 overlap expected
        for (int k = 0; k < hi; k++) begin
            @(negedge clk);
            if (scramble) begin
                line_data = ~line_data;          // R2 late data change
                polarity  = ~polarity;           // R6 late polarity change
            end
        end
        strobe = 1'b0;
        for (int k = 0; k < lo; k++) @(negedge clk);
        last_low = lo;
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (mon_on) begin
            if (q.size() > 0 && q[0].due == cyc) begin
                exp_code = q[0].data;
                exp_pol  = q[0].pol;
                exp_drv  = 1'b1;
                void'(q.pop_front());
            end
            for (int i = 0; i < NCH; i++)
                exp_grp[i] = !exp_drv ? 1'b0 : (((i % 2) == 0) ? exp_pol : ~exp_pol);
            check(out_code == exp_code, "R2,R3,R10 codes", out_code, exp_code);
            check(out_grp == exp_grp, "R4,R5,R6 groups", BW'(out_grp), BW'(exp_grp));
            check(drive_en == exp_drv, "R7 drive_en", BW'(drive_en), BW'(exp_drv));
            check(bias_low == bias_model, "R8 bias_low", BW'(bias_low), BW'(bias_model));
            check(strobe_err == (cyc == err_due), "R9 strobe_err",
                  BW'(strobe_err), BW'(cyc == err_due));
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state visible before any strobe
        check(out_code == '0 && out_grp == '0 && !drive_en && !bias_low && !strobe_err,
              "R1 reset state", out_code, '0);
        mon_on = 1'b1;
        repeat (3) @(negedge clk);
        // R1: stays idle with no strobe
        check(drive_en == 1'b0, "R1 idle", BW'(drive_en), '0);

        send_line(make_line(3), 1'b0, 2, 3, 1'b0);           // R4
        send_line(make_line(7), 1'b1, 3, 2, 1'b0);           // R5
        send_line(make_line(11), 1'b0, 4, 3, 1'b1);          // R2 R6 scramble
        low_power_n = 1'b0;                                  // R8
        send_line({BW{1'b1}}, 1'b1, 1, 2, 1'b1);             // R10 all ones
        send_line(make_line(5), 1'b0, 6, 1, 1'b0);           // R3 long high
        send_line(make_line(13), 1'b1, 2, 1, 1'b1);          // R9 overlap
        low_power_n = 1'b1;
        send_line(make_line(17), 1'b0, 1, 1, 1'b0);          // R9 overlap again
        send_line('0, 1'b1, 2, 2, 1'b0);                     // R9 no error, zeros
        send_line(make_line(19), 1'b0, 3, 4, 1'b1);
        repeat (8) @(negedge clk);
        check(q.size() == 0, "R3 all lines committed", BW'(q.size()), '0);
        done = 1'b1;
        finish_run();
    end

endmodule